// File: doc/BRIEF.md
# Token-Addressed Calibration Code Loader

This block distributes 7-bit calibration words to a row of delay-cell/comparator sets. Each set keeps its own word in a wide storage register. A single shared data bus feeds every register. A chain of single-bit token stages, one stage per set, picks which register captures the bus. This replaces a long serial shift path that would need one flip-flop for every stored bit.

A load sequence begins with a one-cycle start pulse, which places the token on set 0. Each data-valid strobe writes the bus word into the set that holds the token, and then moves the token on to the next set. When the last set has been written, the token leaves the chain and a done flag rises. Strobes then have no effect until the next start. Each stored word is presented to its set as a 4-bit delay code and a 3-bit comparator offset code. Only the synchronous reset clears the stored words.

Top module: `cal_code_loader`

## Requirements
- R1: While reset is high, every stored word becomes zero and done is low from the next clock edge onward.
- R2: A start pulse places the token on set 0, so the first accepted strobe after it writes set 0.
- R3: An accepted strobe writes the data bus into exactly one set, and every other set keeps its value.
- R4: Accepted strobes fill the sets in ascending index order: the k-th strobe after a start writes set k. Cycles without a strobe leave the token where it is.
- R5: Data bits 6 to 3 of a written word appear on that set's 4-bit delay code, at dly_code_o[4*i+3:4*i]. Data bits 2 to 0 appear on its 3-bit offset code, at ofs_code_o[3*i+2:3*i].
- R6: done rises on the edge that writes the last set. From then on, strobes change no stored word and done stays high.
- R7: A start clears done on its edge and leaves every stored word unchanged. Each word is replaced only when its set is written again.
- R8: A strobe in the same cycle as a start is discarded. Start takes priority.
- R9: Strobes after reset and before any start write nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load-start pulse |
| valid_i | input | 1 | Data-valid strobe |
| data_i | input | 7 | Shared calibration word bus: delay code in bits 6:3, offset code in bits 2:0 |
| dly_code_o | output | 4*NUM_SETS | Per-set delay codes, set i at bits 4i+3:4i |
| ofs_code_o | output | 3*NUM_SETS | Per-set offset codes, set i at bits 3i+2:3i |
| done_o | output | 1 | High once every set of the current load has been written |

## Verification
The assertions assume that start_i, valid_i and data_i hold known values at every clock edge. They also assume that start and strobe are level-sampled one-cycle events. A strobe held high for several cycles counts as several writes. The bench drives every input on the falling edge and holds each pulse for exactly one cycle. It leaves idle gaps between strobes, and it deliberately lines up a start with a strobe in one case. This stays inside those assumptions while still reaching the collision and the post-done cases.

// File: rtl/cal_loader_pkg.sv
package cal_loader_pkg;

    localparam int DLY_W  = 4;
    localparam int OFS_W  = 3;
    localparam int WORD_W = DLY_W + OFS_W;

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic [OFS_W-1:0] ofs;
    } cal_word_t;

    function automatic cal_word_t split_word(input logic [WORD_W-1:0] raw);
        cal_word_t w;
        w.dly = raw[WORD_W-1:OFS_W];
        w.ofs = raw[OFS_W-1:0];
        return w;
    endfunction

endpackage

// File: rtl/cal_token_chain.sv
module cal_token_chain #(
    parameter int NUM_SETS = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                start_i,
    input  logic                step_i,
    output logic [NUM_SETS-1:0] token_o
);

    logic [NUM_SETS-1:0] tok_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SETS; gi++) begin : g_stage
            logic prev_tok;
            if (gi == 0) begin : g_head
                assign prev_tok = 1'b0;
            end else begin : g_body
                assign prev_tok = tok_q[gi-1];
            end

            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    tok_q[gi] <= 1'b0;
                end else if (start_i) begin
                    tok_q[gi] <= (gi == 0);
                end else if (step_i) begin
                    tok_q[gi] <= prev_tok;
                end
            end
        end
    endgenerate

    assign token_o = tok_q;

endmodule

// File: rtl/cal_code_bank.sv
module cal_code_bank
    import cal_loader_pkg::*;
#(
    parameter int NUM_SETS = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_SETS-1:0] wen_i,
    input  cal_word_t           wdata_i,
    output cal_word_t           words_o [NUM_SETS]
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SETS; gi++) begin : g_set
            cal_word_t word_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    word_q <= '0;
                end else if (wen_i[gi]) begin
                    word_q <= wdata_i;
                end
            end
            assign words_o[gi] = word_q;
        end
    endgenerate

endmodule

// File: rtl/cal_load_ctrl.sv
module cal_load_ctrl #(
    parameter int NUM_SETS = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                start_i,
    input  logic                valid_i,
    input  logic [NUM_SETS-1:0] token_i,
    output logic                step_o,
    output logic [NUM_SETS-1:0] wen_o,
    output logic                done_o
);

    logic done_q;

    always_comb begin
        step_o = valid_i && !start_i && (|token_i);
        wen_o  = token_i & {NUM_SETS{step_o}};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            done_q <= 1'b0;
        end else if (start_i) begin
            done_q <= 1'b0;
        end else if (step_o && token_i[NUM_SETS-1]) begin
            done_q <= 1'b1;
        end
    end

    assign done_o = done_q;

endmodule

// File: rtl/cal_code_loader.sv
module cal_code_loader
    import cal_loader_pkg::*;
#(
    parameter int NUM_SETS = 8
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      start_i,
    input  logic                      valid_i,
    input  logic [WORD_W-1:0]         data_i,
    output logic [NUM_SETS*DLY_W-1:0] dly_code_o,
    output logic [NUM_SETS*OFS_W-1:0] ofs_code_o,
    output logic                      done_o
);

    logic [NUM_SETS-1:0] token_q;
    logic [NUM_SETS-1:0] wen;
    logic                step;
    cal_word_t           words [NUM_SETS];

    cal_load_ctrl #(.NUM_SETS(NUM_SETS)) ctrl_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .valid_i (valid_i),
        .token_i (token_q),
        .step_o  (step),
        .wen_o   (wen),
        .done_o  (done_o)
    );

    cal_token_chain #(.NUM_SETS(NUM_SETS)) chain_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .step_i  (step),
        .token_o (token_q)
    );

    cal_code_bank #(.NUM_SETS(NUM_SETS)) bank_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wen_i   (wen),
        .wdata_i (split_word(data_i)),
        .words_o (words)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SETS; gi++) begin : g_out
            assign dly_code_o[gi*DLY_W +: DLY_W] = words[gi].dly;
            assign ofs_code_o[gi*OFS_W +: OFS_W] = words[gi].ofs;
        end
    endgenerate

endmodule

// File: rtl/cal_code_loader_chk.sv
module cal_code_loader_chk
    import cal_loader_pkg::*;
#(
    parameter int NUM_SETS = 8
) (
    input logic                      clk_i,
    input logic                      rst_i,
    input logic                      start_i,
    input logic                      valid_i,
    input logic [NUM_SETS*DLY_W-1:0] dly_code_o,
    input logic [NUM_SETS*OFS_W-1:0] ofs_code_o,
    input logic                      done_o,
    input logic [NUM_SETS-1:0]       token_q
);

    // R1: reset clears the stored words and done
    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (dly_code_o == '0 && ofs_code_o == '0 && !done_o));

    // R2: start places the token on set 0
    p_start_head_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (token_q == NUM_SETS'(1)));

    // R3: at most one set holds the token
    p_token_single_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(token_q));

    // R4: an accepted strobe moves the token one set up
    p_token_advance_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && !start_i && token_q != '0 && !token_q[NUM_SETS-1])
        |=> (token_q == ($past(token_q) << 1)));

    // R4: no strobe and no start keeps the token in place
    p_token_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!valid_i && !start_i) |=> $stable(token_q));

    // R6: writing the last set raises done
    p_last_done_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && !start_i && token_q[NUM_SETS-1]) |=> (done_o && token_q == '0));

    // R6 and R9: with no token, nothing changes
    p_no_token_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (token_q == '0 && !start_i) |=> ($stable(dly_code_o) && $stable(ofs_code_o)));

    // R7: start clears done and leaves the codes intact
    p_start_keep_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (!done_o && $stable(dly_code_o) && $stable(ofs_code_o)));

endmodule

bind cal_code_loader cal_code_loader_chk #(.NUM_SETS(NUM_SETS)) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .start_i    (start_i),
    .valid_i    (valid_i),
    .dly_code_o (dly_code_o),
    .ofs_code_o (ofs_code_o),
    .done_o     (done_o),
    .token_q    (token_q)
);

// File: tb/cal_code_loader_tb_top.sv
`timescale 1ns/1ps
module cal_code_loader_tb_top;

    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic           start;
    logic           valid;
    logic [6:0]     data;
    logic [N*4-1:0] dly;
    logic [N*3-1:0] ofs;
    logic           done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [6:0] model [N];

    always #2.5 clk = ~clk;

    cal_code_loader #(.NUM_SETS(N)) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .start_i    (start),
        .valid_i    (valid),
        .data_i     (data),
        .dly_code_o (dly),
        .ofs_code_o (ofs),
        .done_o     (done)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        for (int i = 0; i < N; i++) begin
            chk($sformatf("%s set%0d dly", tag, i), int'(dly[i*4 +: 4]), int'(model[i][6:3]));
            chk($sformatf("%s set%0d ofs", tag, i), int'(ofs[i*3 +: 3]), int'(model[i][2:0]));
        end
    endtask

    task automatic pulse(input bit s, input bit v, input logic [6:0] d);
        start = s; valid = v; data = d;
        @(negedge clk);
        start = 0; valid = 0; data = 7'h00;
    endtask

    task automatic t_reset();
        rst = 1; start = 0; valid = 0; data = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        for (int i = 0; i < N; i++) model[i] = '0;
        chk_all("R1 reset");
        chk("R1 done after reset", int'(done), 0);
    endtask

    task automatic t_no_start();
        pulse(0, 1, 7'h55);
        @(negedge clk);
        pulse(0, 1, 7'h2A);
        chk_all("R9 strobe without start");
        chk("R9 done", int'(done), 0);
    endtask

    task automatic t_full_load();
        pulse(1, 0, 0);
        chk("R2 done after start", int'(done), 0);
        for (int k = 0; k < N; k++) begin
            logic [6:0] w;
            w = 7'((k * 37 + 11) ^ 7'h5A);
            pulse(0, 1, w);
            model[k] = w;
            chk_all($sformatf("R3 R4 R5 strobe%0d", k));
            if (k < N - 1) chk("R6 done early", int'(done), 0);
            if (k % 2 == 0) @(negedge clk);
        end
        chk("R6 done after last", int'(done), 1);
    endtask

    task automatic t_after_done();
        pulse(0, 1, 7'h7F);
        pulse(0, 1, 7'h01);
        chk_all("R6 strobe after done");
        chk("R6 done held", int'(done), 1);
    endtask

    task automatic t_reload();
        pulse(1, 0, 0);
        chk("R7 done cleared", int'(done), 0);
        chk_all("R7 codes kept on start");
        for (int k = 0; k < 3; k++) begin
            pulse(0, 1, 7'(7'h40 + k));
            model[k] = 7'(7'h40 + k);
        end
        chk_all("R7 partial reload");
        chk("R7 done partial", int'(done), 0);
    endtask

    task automatic t_collide();
        pulse(1, 1, 7'h3C);
        chk_all("R8 strobe with start");
        pulse(0, 1, 7'h66);
        model[0] = 7'h66;
        chk_all("R8 R2 first write after collide");
    endtask

    task automatic t_reset_again();
        rst = 1;
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < N; i++) model[i] = '0;
        chk_all("R1 mid-run reset");
        chk("R1 done mid-run reset", int'(done), 0);
        pulse(0, 1, 7'h12);
        chk_all("R9 strobe after reset");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_no_start();
        t_full_load();
        t_after_done();
        t_reload();
        t_collide();
        t_reset_again();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule